// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management registers of a Fast Ethernet PHY as the MAC sees them through its register interface. Software first loads a target word that picks a PHY address and a register index. It then reads the selected 16-bit register, or writes a 16-bit value to it. A link-status input keeps the status register and the link-partner ability register in line with the current link.

The block covers the control, status, two identifier, advertisement, link-partner and expansion registers. Vendor and undefined indices read as zero. Bit-level serial framing and on-wire autonegotiation are not part of it.

Register indices are control 0, status 1, identifier high 2, identifier low 3, advertisement 4, link partner 5, expansion 6.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, control reads 0x3100, which is duplex bit 8, autonegotiation enable bit 12 and speed bit 13. Advertisement reads 0x01E1, which is 100TX full duplex bit 8, 100TX bit 7, 10 full duplex bit 6, 10 bit 5 and selector 0x01. Status reads 0x7848 with the link down.
- R2: When the address field of the target differs from PHY_ADDR, a read returns 0xFFFF.
- R3: When the address field of the target differs from PHY_ADDR, a write changes no register.
- R4: One cycle after link_up_i goes high, status reads 0x786C (link bit 2 and autonegotiation-complete bit 5 set) and link partner reads 0x01E1.
- R5: One cycle after link_up_i goes low, status reads 0x7848 and link partner reads 0x0080 (100TX only).
- R6: A control write with bit 15 clear stores the written value, which reads back from the next cycle on.
- R7: A control write with bit 15 set is not stored. Control and advertisement return to their reset values, and status and link partner keep following the current link.
- R8: A write to the advertisement register stores the value.
- R9: Writes to status, both identifier registers, link partner and expansion change nothing.
- R10: The expansion register, vendor indices 16 to 31 and every other undefined index read as 0x0000.
- R11: The identifier registers read the PHY_ID_HI and PHY_ID_LO parameters.
- R12: The target word carries the register index in bits [7:0] and the PHY address in bits [15:8]. It is loaded when target_we_i is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| target_we_i | input | 1 | Load the target word |
| target_i | input | 16 | Target word: PHY address [15:8], register index [7:0] |
| wr_en_i | input | 1 | Write wr_data_i to the targeted register |
| wr_data_i | input | 16 | Write data |
| link_up_i | input | 1 | Current link state |
| rd_data_o | output | 16 | Data of the targeted register |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A target load is registered once, and rd_data_o then follows combinationally. Register writes and link_up_i changes are likewise captured once and are visible from the following cycle.

The bench drives all inputs on the falling edge and samples rd_data_o on the next falling edge. One rising edge therefore falls between stimulus and check, and nothing is sampled beyond it.

A bench model is updated at that same point. It checks both directed corners and seeded random sequences of target loads, writes and link changes.

// File: rtl/phy_mgmt_pkg.sv
`timescale 1ns/1ps
package phy_mgmt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned FLD_W  = 8;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic [FLD_W-1:0] addr;
    logic [FLD_W-1:0] idx;
  } target_t;

  localparam logic [FLD_W-1:0] IDX_CTRL  = 8'd0;
  localparam logic [FLD_W-1:0] IDX_STAT  = 8'd1;
  localparam logic [FLD_W-1:0] IDX_ID_HI = 8'd2;
  localparam logic [FLD_W-1:0] IDX_ID_LO = 8'd3;
  localparam logic [FLD_W-1:0] IDX_ADV   = 8'd4;
  localparam logic [FLD_W-1:0] IDX_LP    = 8'd5;
  localparam logic [FLD_W-1:0] IDX_EXP   = 8'd6;

  localparam int unsigned CTRL_RST_BIT   = 15;
  localparam int unsigned CTRL_SPEED_BIT = 13;
  localparam int unsigned CTRL_AN_BIT    = 12;
  localparam int unsigned CTRL_FD_BIT    = 8;

  localparam int unsigned STAT_LINK_BIT  = 2;
  localparam int unsigned STAT_ANC_BIT   = 5;

  localparam word_t CTRL_DEFAULT = word_t'((1 << CTRL_SPEED_BIT) | (1 << CTRL_AN_BIT) |
                                           (1 << CTRL_FD_BIT));
  // abilities: 100TX FD/HD, 10T FD/HD, preamble suppression, autoneg
  localparam word_t STAT_BASE    = word_t'((1 << 14) | (1 << 13) | (1 << 12) | (1 << 11) |
                                           (1 << 6) | (1 << 3));
  localparam word_t STAT_LINKED  = word_t'((1 << STAT_LINK_BIT) | (1 << STAT_ANC_BIT));

  localparam word_t ABL_TXFD     = word_t'(1 << 8);
  localparam word_t ABL_TX       = word_t'(1 << 7);
  localparam word_t ABL_10FD     = word_t'(1 << 6);
  localparam word_t ABL_10       = word_t'(1 << 5);
  localparam word_t ABL_SEL      = word_t'(1);

  localparam word_t ADV_DEFAULT  = ABL_TXFD | ABL_TX | ABL_10FD | ABL_10 | ABL_SEL;
  localparam word_t LP_DOWN      = ABL_TX;
  localparam word_t LP_UP        = ABL_TX | ABL_TXFD | ABL_10FD | ABL_10 | ABL_SEL;
endpackage

// File: rtl/phy_mgmt_target.sv
`timescale 1ns/1ps
module phy_mgmt_target
  import phy_mgmt_pkg::*;
#(
  parameter logic [FLD_W-1:0] PHY_ADDR = 8'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  target_t          target_i,
  output logic             hit_o,
  output logic [FLD_W-1:0] idx_o
);
  target_t target_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   target_q <= '0;
    else if (we_i) target_q <= target_i;
  end

  assign hit_o = (target_q.addr == PHY_ADDR);
  assign idx_o = target_q.idx;

  AST_TARGET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (idx_o == $past(target_i.idx))); // R12
endmodule

// File: rtl/phy_mgmt_regs.sv
`timescale 1ns/1ps
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [FLD_W-1:0] idx_i,
  input  word_t            data_i,
  input  logic             link_up_i,
  output word_t            ctrl_o,
  output word_t            adv_o,
  output word_t            stat_o,
  output word_t            lp_o
);
  word_t ctrl_q, adv_q;
  logic  link_q;
  logic  ctrl_wr, adv_wr, soft_rst;

  assign ctrl_wr  = wr_i && (idx_i == IDX_CTRL);
  assign adv_wr   = wr_i && (idx_i == IDX_ADV);
  assign soft_rst = ctrl_wr && data_i[CTRL_RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_DEFAULT;
      adv_q  <= ADV_DEFAULT;
      link_q <= 1'b0;
    end else begin
      link_q <= link_up_i;
      if (soft_rst) begin
        ctrl_q <= CTRL_DEFAULT;
        adv_q  <= ADV_DEFAULT;
      end else begin
        if (ctrl_wr) ctrl_q <= data_i;
        if (adv_wr)  adv_q  <= data_i;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign adv_o  = adv_q;
  assign stat_o = link_q ? (STAT_BASE | STAT_LINKED) : STAT_BASE;
  assign lp_o   = link_q ? LP_UP : LP_DOWN;

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (ctrl_o == CTRL_DEFAULT) && (adv_o == ADV_DEFAULT)); // R7
  AST_CTRL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !data_i[CTRL_RST_BIT]) |=> (ctrl_o == $past(data_i))); // R6
  AST_ADV_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_wr |=> (adv_o == $past(data_i))); // R8
  AST_ADV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr || adv_wr) |=> $stable(adv_o)); // R9
  AST_CTRL_NO_RST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !ctrl_o[CTRL_RST_BIT]); // R7
  AST_LINK_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_i |=> stat_o[STAT_LINK_BIT] && stat_o[STAT_ANC_BIT] && (lp_o == LP_UP)); // R4
  AST_LINK_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |=> !stat_o[STAT_LINK_BIT] && (lp_o == LP_DOWN)); // R5
endmodule

// File: rtl/phy_mgmt_rdmux.sv
`timescale 1ns/1ps
module phy_mgmt_rdmux
  import phy_mgmt_pkg::*;
#(
  parameter word_t PHY_ID_HI = 16'h0123,
  parameter word_t PHY_ID_LO = 16'h4567
) (
  input  logic             hit_i,
  input  logic [FLD_W-1:0] idx_i,
  input  word_t            ctrl_i,
  input  word_t            adv_i,
  input  word_t            stat_i,
  input  word_t            lp_i,
  output word_t            data_o
);
  word_t local_rd;

  always_comb begin
    unique case (idx_i)
      IDX_CTRL:  local_rd = ctrl_i;
      IDX_STAT:  local_rd = stat_i;
      IDX_ID_HI: local_rd = PHY_ID_HI;
      IDX_ID_LO: local_rd = PHY_ID_LO;
      IDX_ADV:   local_rd = adv_i;
      IDX_LP:    local_rd = lp_i;
      default:   local_rd = '0;   // expansion, vendor, undefined
    endcase
  end

  assign data_o = hit_i ? local_rd : '1;

  always_comb begin
    if (hit_i && (idx_i > IDX_LP)) AST_UNDEF_ZERO: assert (data_o == '0); // R10
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
`timescale 1ns/1ps
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter logic [7:0]  PHY_ADDR  = 8'd1,
  parameter logic [15:0] PHY_ID_HI = 16'h0123,
  parameter logic [15:0] PHY_ID_LO = 16'h4567
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        target_we_i,
  input  logic [15:0] target_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        link_up_i,
  output logic [15:0] rd_data_o
);
  logic             hit;
  logic [FLD_W-1:0] idx;
  word_t            ctrl, adv, stat, lp;

  phy_mgmt_target #(.PHY_ADDR(PHY_ADDR)) u_target (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (target_we_i),
    .target_i (target_t'(target_i)),
    .hit_o    (hit),
    .idx_o    (idx)
  );

  phy_mgmt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i && hit),
    .idx_i     (idx),
    .data_i    (wr_data_i),
    .link_up_i (link_up_i),
    .ctrl_o    (ctrl),
    .adv_o     (adv),
    .stat_o    (stat),
    .lp_o      (lp)
  );

  phy_mgmt_rdmux #(.PHY_ID_HI(PHY_ID_HI), .PHY_ID_LO(PHY_ID_LO)) u_rdmux (
    .hit_i  (hit),
    .idx_i  (idx),
    .ctrl_i (ctrl),
    .adv_i  (adv),
    .stat_i (stat),
    .lp_i   (lp),
    .data_o (rd_data_o)
  );

  AST_FOREIGN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rd_data_o == 16'hFFFF)); // R2
  AST_FOREIGN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(ctrl) && $stable(adv)); // R3
endmodule

// File: tb/phy_mgmt_regfile_tb.sv
`timescale 1ns/1ps
module phy_mgmt_regfile_tb_top;
  localparam logic [7:0]  PHY_ADDR = 8'd1;
  localparam logic [15:0] ID_HI    = 16'h0123;
  localparam logic [15:0] ID_LO    = 16'h4567;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        target_we_i = 1'b0;
  logic [15:0] target_i = '0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        link_up_i = 1'b0;
  logic [15:0] rd_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl, m_adv;
  bit          m_link;
  logic [7:0]  cur_addr, cur_idx;

  always #2.5 clk_i = ~clk_i;

  phy_mgmt_regfile #(.PHY_ADDR(PHY_ADDR), .PHY_ID_HI(ID_HI), .PHY_ID_LO(ID_LO)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .target_we_i(target_we_i), .target_i(target_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .link_up_i(link_up_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [15:0] exp_read(logic [7:0] a, logic [7:0] i);
    if (a != PHY_ADDR) return 16'hFFFF;
    case (i)
      8'd0: return m_ctrl;
      8'd1: return m_link ? 16'h786C : 16'h7848;
      8'd2: return ID_HI;
      8'd3: return ID_LO;
      8'd4: return m_adv;
      8'd5: return m_link ? 16'h01E1 : 16'h0080;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string tag);
    logic [15:0] e;
    e = exp_read(cur_addr, cur_idx);
    checks++;
    if (rd_data_o !== e) begin
      failures++;
      $display("FAIL %s addr=%0h idx=%0h actual=%04h expected=%04h", tag, cur_addr, cur_idx,
               rd_data_o, e);
    end
  endtask

  task automatic set_target(logic [7:0] a, logic [7:0] i);
    @(negedge clk_i);
    target_we_i = 1'b1;
    target_i = {a, i};
    @(negedge clk_i);
    target_we_i = 1'b0;
    cur_addr = a;
    cur_idx = i;
  endtask

  task automatic write_val(logic [15:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (cur_addr == PHY_ADDR) begin
      if (cur_idx == 8'd0) begin
        if (v[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
        else m_ctrl = v;
      end else if (cur_idx == 8'd4) m_adv = v;
    end
  endtask

  task automatic set_link(bit l);
    @(negedge clk_i);
    link_up_i = l;
    @(negedge clk_i);
    m_link = l;
  endtask

  task automatic read_check(logic [7:0] a, logic [7:0] i, string tag);
    set_target(a, i);
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = 16'h3100; m_adv = 16'h01E1; m_link = 1'b0;
    cur_addr = 8'd0; cur_idx = 8'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values, link down
    read_check(PHY_ADDR, 8'd0, "R1 ctrl");
    read_check(PHY_ADDR, 8'd4, "R1 adv");
    read_check(PHY_ADDR, 8'd1, "R1 stat");
    // R11 identifiers
    read_check(PHY_ADDR, 8'd2, "R11 id_hi");
    read_check(PHY_ADDR, 8'd3, "R11 id_lo");
    // R5 link partner with link down
    read_check(PHY_ADDR, 8'd5, "R5 lp down");
    // R4 link up
    set_link(1'b1);
    check("R4 lp up");
    read_check(PHY_ADDR, 8'd1, "R4 stat up");
    // R5 link down again
    set_link(1'b0);
    check("R5 stat down");
    // R12 field layout: address in upper byte
    cur_addr = 8'd0; cur_idx = PHY_ADDR;
    set_target(8'd0, PHY_ADDR);
    check("R12 swapped fields");
    read_check(PHY_ADDR, 8'd0, "R12 proper fields");
    // R2 / R3 foreign address
    read_check(8'd7, 8'd0, "R2 foreign read");
    write_val(16'h0000);
    read_check(PHY_ADDR, 8'd0, "R3 foreign write ignored");
    // R6 control store
    write_val(16'h1234);
    check("R6 ctrl store");
    // R8 advertisement store
    set_target(PHY_ADDR, 8'd4);
    write_val(16'h0061);
    check("R8 adv store");
    // R7 control reset bit restores defaults
    set_link(1'b1);
    set_target(PHY_ADDR, 8'd0);
    write_val(16'h8000);
    check("R7 ctrl default");
    read_check(PHY_ADDR, 8'd4, "R7 adv default");
    read_check(PHY_ADDR, 8'd1, "R7 stat keeps link");
    // R9 read-only registers
    for (int i = 1; i <= 6; i++) begin
      if (i == 4) continue;
      set_target(PHY_ADDR, 8'(i));
      write_val(16'hA5A5);
      check("R9 read-only write");
    end
    // R10 expansion, vendor, undefined
    read_check(PHY_ADDR, 8'd6, "R10 expansion");
    read_check(PHY_ADDR, 8'd16, "R10 vendor");
    read_check(PHY_ADDR, 8'd31, "R10 vendor top");
    read_check(PHY_ADDR, 8'd255, "R10 undefined");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] a, i;
      op = int'($urandom_range(0, 3));
      a = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(0, 255)) : PHY_ADDR;
      i = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 7));
      case (op)
        0: read_check(a, i, "R2 R10 random read");
        1: begin
          set_target(a, i);
          write_val(($urandom_range(0, 3) == 0) ? 16'($urandom) | 16'h8000 :
                                                  16'($urandom) & 16'h7FFF);
          check("R3 R6 R7 R8 R9 random write");
        end
        2: begin set_link(bit'($urandom_range(0, 1))); check("R4 R5 random link"); end
        default: begin
          set_target(PHY_ADDR, 8'($urandom_range(0, 5)));
          check("R1 R11 random sweep");
        end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule